// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block watches a stream of 8-bit or 16-bit video words for the four-word timing reference: a 0xFF word, two 0x00 words, then a status word. The status word is decoded into a start-of-active or end-of-active pulse, the task, field and vertical flags, and four extended flags. Between a start code and the next end code, the block delivers the samples with a data-valid strobe. Each sample carries a tag that says whether it belongs to active video or to the blanking-interval data stream.

Two flag-timing variants are selected at run time by a level input. In legacy mode, the flags change only at end codes, and the task bit tells blanking-interval data (0) apart from active video (1). In the newer mode, the flags load at both kinds of code. In this mode the task bit separates two interleaved streams, V marks blanking-interval data, and the low nibble of the status word is decoded as extended flags. The 16-bit variant carries the timing codes on the low byte lane. The high byte passes through as sample data only.

Top module: `vtc_decoder`

## Requirements
- R1: When the word after an 0xFF, 0x00, 0x00 run arrives on the low byte lane, it is taken as the status word. Status word bits are T=bit 7, F=bit 6, V=bit 5, H=bit 4. One clock edge later, `sav_o` pulses for one cycle if H=0, and `eav_o` pulses for one cycle if H=1.
- R2: A run that breaks before it is complete (0xFF followed by anything other than 0x00, 0x00) produces no pulse and leaves all flags unchanged. An 0xFF word restarts the match.
- R3: In the 16-bit variant, only bits [7:0] take part in code matching. 0xFF or 0x00 values in bits [15:8] never produce a code.
- R4: With `legacy_i`=1, `task_o`, `field_o` and `vblank_o` load from bits 7, 6 and 5 only at an end code. A start code leaves them unchanged.
- R5: With `legacy_i`=0, `task_o`, `field_o` and `vblank_o` load from bits 7, 6 and 5 at every start code and every end code.
- R6: With `legacy_i`=0, `ext_o` loads the status word's bits [3:0] at every code. The fields are ext_o[3]=non-interlaced, ext_o[2]=repeat, ext_o[1]=reserved, ext_o[0]=extension. With `legacy_i`=1, `ext_o` reads 0 from the next edge onward.
- R7: `data_valid_o` is high only for samples that arrive after a start code's status word and before the 0xFF that opens the next code. The timing code words themselves are never marked valid. Valid samples appear on `data_o` in their arrival order, unaltered, three edges after they are captured.
- R8: `tag_vbi_o` is fixed for each line at its start code. In legacy mode it is 1 when the task flag then held is 0. In the newer mode it equals the start code's V bit.
- R9: While `rst_n` is low, every output is 0 from the first clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one word per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| legacy_i | input | 1 | 1 selects legacy flag timing, 0 selects the newer rules |
| sample_i | input | DATA_W | Incoming video word; codes on bits [7:0] |
| sav_o | output | 1 | One-cycle start-of-active pulse |
| eav_o | output | 1 | One-cycle end-of-active pulse |
| task_o | output | 1 | Task flag |
| field_o | output | 1 | Field flag |
| vblank_o | output | 1 | Vertical flag |
| ext_o | output | 4 | Extended flags {non-interlaced, repeat, reserved, extension} |
| data_valid_o | output | 1 | `data_o` holds an active-region sample |
| data_o | output | DATA_W | Delayed sample |
| tag_vbi_o | output | 1 | 1 when the sample belongs to the blanking-interval stream |

## Verification
The bench builds the block with DATA_W=16. This brings the lane split within reach: the high byte carries 0xFF and 0x00 words, in code order, in the middle of active lines, and it must not trigger matching. It also must come out unchanged in the sample data. In one run, the bench visits both flag-timing variants. This includes start codes whose flag bits differ from the held values in legacy mode, interleaved task values in the newer mode, and broken preambles both in blanking and inside active lines.

// File: rtl/vtc_pkg.sv
// Package: shared constants and the decoded status-word layout for the
// video timing reference decoder. Assumes the preamble is one high marker
// word followed by low marker words, PRE_LEN words in all.
package vtc_pkg;
    localparam int          PRE_LEN = 3;
    localparam logic [7:0]  MARK_HI = 8'hFF;
    localparam logic [7:0]  MARK_LO = 8'h00;

    // Status word as it arrives on the low byte lane.
    typedef struct packed {
        logic       task_b;
        logic       field;
        logic       vert;
        logic       hpos;
        logic [3:0] ext;
    } status_t;
endpackage

// File: rtl/vtc_seq_matcher.sv
// Module: vtc_seq_matcher
// Tracks how much of the timing preamble has been seen on the low byte lane
// and flags the word that follows a complete preamble as a status word.
// Assumes one word per clock; a broken run restarts the count, and a high
// marker word always counts as a fresh start.
module vtc_seq_matcher
    import vtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] lane_i,
    output logic       hit_o,
    output status_t    status_o
);
    localparam int CNT_W = $clog2(PRE_LEN + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(PRE_LEN);

    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] seen_d;
    logic             is_hi;
    logic             is_lo;

    assign is_hi    = (lane_i == MARK_HI);
    assign is_lo    = (lane_i == MARK_LO);
    assign hit_o    = (seen_q == FULL);
    assign status_o = status_t'(lane_i);

    // Next preamble count from the current word.
    always_comb begin
        if (hit_o) begin
            seen_d = '0;
        end else if (seen_q == '0) begin
            seen_d = is_hi ? CNT_W'(1) : '0;
        end else if (is_lo) begin
            seen_d = seen_q + CNT_W'(1);
        end else begin
            seen_d = is_hi ? CNT_W'(1) : '0;
        end
    end

    // Preamble count register.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end
endmodule

// File: rtl/vtc_flag_regs.sv
// Module: vtc_flag_regs
// Holds the task, field and vertical flags and the extended nibble, and
// raises the start and end pulses. Applies the legacy rule (flags move only
// at end codes, no extended flags) or the newer rule (flags move at every
// code). It also works out the stream tag for a line that starts now.
module vtc_flag_regs
    import vtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       legacy_i,
    input  logic       hit_i,
    input  status_t    status_i,
    output logic       sav_o,
    output logic       eav_o,
    output logic       task_o,
    output logic       field_o,
    output logic       vert_o,
    output logic [3:0] ext_o,
    output logic       sav_now_o,
    output logic       sav_tag_o
);
    logic load_tfv;

    assign sav_now_o = hit_i & ~status_i.hpos;
    assign load_tfv  = hit_i & (status_i.hpos | ~legacy_i);
    // Legacy: a line is blanking data when the held task flag is 0.
    assign sav_tag_o = legacy_i ? ~task_o : status_i.vert;

    // Start and end pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sav_o <= 1'b0;
            eav_o <= 1'b0;
        end else begin
            sav_o <= hit_i & ~status_i.hpos;
            eav_o <= hit_i &  status_i.hpos;
        end
    end

    // Task, field and vertical flags under the selected update rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_o  <= 1'b0;
            field_o <= 1'b0;
            vert_o  <= 1'b0;
        end else if (load_tfv) begin
            task_o  <= status_i.task_b;
            field_o <= status_i.field;
            vert_o  <= status_i.vert;
        end
    end

    // Extended flags: only meaningful under the newer rule.
    always_ff @(posedge clk) begin
        if (!rst_n)        ext_o <= '0;
        else if (legacy_i) ext_o <= '0;
        else if (hit_i)    ext_o <= status_i.ext;
    end
endmodule

// File: rtl/vtc_sample_pipe.sv
// Module: vtc_sample_pipe
// Delays samples by the preamble length, so that the preamble words of a
// code can be withdrawn once the status word shows they were not video.
// Assumes DEPTH equals the preamble length; one sample per clock.
module vtc_sample_pipe #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              hit_i,
    input  logic              sav_i,
    input  logic              sav_tag_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              tag_o
);
    logic                          in_line_q;
    logic                          line_tag_q;
    logic [DEPTH-1:0][DATA_W-1:0]  st_data;
    logic [DEPTH-1:0]              st_act;
    logic [DEPTH-1:0]              st_tag;

    // Line state: opened by a start code, closed by an end code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_line_q  <= 1'b0;
            line_tag_q <= 1'b0;
        end else if (hit_i) begin
            in_line_q <= sav_i;
            if (sav_i) line_tag_q <= sav_tag_i;
        end
    end

    // Delay line; a status word withdraws every preamble word in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_data <= '0;
            st_act  <= '0;
            st_tag  <= '0;
        end else begin
            st_data[0] <= sample_i;
            st_act[0]  <= in_line_q & ~hit_i;
            st_tag[0]  <= line_tag_q;
            for (int i = 1; i < DEPTH; i++) begin
                st_data[i] <= st_data[i-1];
                st_act[i]  <= st_act[i-1] & ~hit_i;
                st_tag[i]  <= st_tag[i-1];
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            tag_o   <= 1'b0;
        end else begin
            valid_o <= st_act[DEPTH-1] & ~hit_i;
            data_o  <= st_data[DEPTH-1];
            tag_o   <= st_tag[DEPTH-1];
        end
    end
endmodule

// File: rtl/vtc_decoder.sv
// Module: vtc_decoder (top)
// Decodes timing reference codes in an 8- or 16-bit video word stream.
// Assumes the codes travel on bits [7:0]. Any upper lane is sample data only.
module vtc_decoder
    import vtc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sav_o,
    output logic              eav_o,
    output logic              task_o,
    output logic              field_o,
    output logic              vblank_o,
    output logic [3:0]        ext_o,
    output logic              data_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              tag_vbi_o
);
    logic    hit;
    status_t status;
    logic    sav_now;
    logic    sav_tag;

    vtc_seq_matcher u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_i   (sample_i[7:0]),
        .hit_o    (hit),
        .status_o (status)
    );

    vtc_flag_regs u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .legacy_i  (legacy_i),
        .hit_i     (hit),
        .status_i  (status),
        .sav_o     (sav_o),
        .eav_o     (eav_o),
        .task_o    (task_o),
        .field_o   (field_o),
        .vert_o    (vblank_o),
        .ext_o     (ext_o),
        .sav_now_o (sav_now),
        .sav_tag_o (sav_tag)
    );

    vtc_sample_pipe #(
        .DATA_W (DATA_W),
        .DEPTH  (PRE_LEN)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .hit_i     (hit),
        .sav_i     (sav_now),
        .sav_tag_i (sav_tag),
        .valid_o   (data_valid_o),
        .data_o    (data_o),
        .tag_o     (tag_vbi_o)
    );
endmodule

// File: rtl/vtc_decoder_chk.sv
// Module: vtc_decoder_chk
// Checks timing relations on the top-level ports of vtc_decoder.
// Attached by the bind statement at the end of this file.
module vtc_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       legacy_i,
    input logic       sav_o,
    input logic       eav_o,
    input logic       task_o,
    input logic       field_o,
    input logic       vblank_o,
    input logic [3:0] ext_o,
    input logic       data_valid_o,
    input logic       tag_vbi_o
);
    p_code_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sav_o && eav_o));

    p_code_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sav_o || eav_o) |=> !(sav_o || eav_o));

    p_legacy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(legacy_i) && !eav_o) |-> $stable({task_o, field_o, vblank_o}));

    p_ext_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(legacy_i) |-> (ext_o == 4'b0000));

    p_tag_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid_o && $past(data_valid_o)) |-> $stable(tag_vbi_o));
endmodule

bind vtc_decoder vtc_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .legacy_i     (legacy_i),
    .sav_o        (sav_o),
    .eav_o        (eav_o),
    .task_o       (task_o),
    .field_o      (field_o),
    .vblank_o     (vblank_o),
    .ext_o        (ext_o),
    .data_valid_o (data_valid_o),
    .tag_vbi_o    (tag_vbi_o)
);

// File: tb/vtc_decoder_tb.sv
// Scoreboard bench for vtc_decoder built with a 16-bit word.
module vtc_decoder_tb;
    localparam int CLK_NS = 10;
    localparam int DW     = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          legacy = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          sav_o, eav_o, task_o, field_o, vblank_o;
    logic [3:0]    ext_o;
    logic          data_valid_o;
    logic [DW-1:0] data_o;
    logic          tag_vbi_o;

    int n_chk = 0;
    int n_fail = 0;
    int pulses_seen = 0;
    int pulses_exp = 0;
    logic [DW:0] exp_q[$];

    logic       m_t = 1'b0, m_f = 1'b0, m_v = 1'b0, m_tag = 1'b0;
    logic [3:0] m_ext = 4'h0;

    always #(CLK_NS/2) clk = ~clk;

    vtc_decoder #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .legacy_i(legacy), .sample_i(sample),
        .sav_o(sav_o), .eav_o(eav_o), .task_o(task_o), .field_o(field_o),
        .vblank_o(vblank_o), .ext_o(ext_o), .data_valid_o(data_valid_o),
        .data_o(data_o), .tag_vbi_o(tag_vbi_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Driver: one word per cycle; valid words go to the scoreboard.
    task automatic put(input logic [7:0] up, input logic [7:0] lo, input bit valid);
        @(negedge clk);
        sample = {up, lo};
        if (valid) exp_q.push_back({m_tag, up, lo});
    endtask

    // Driver for a full code, with checks one edge after the status word.
    task automatic code(input logic [7:0] xy, input logic [7:0] nup,
                        input logic [7:0] nlo, input bit nvalid);
        bit h;
        put(8'h5A, 8'hFF, 1'b0);
        put(8'h00, 8'h00, 1'b0);
        put(8'hFF, 8'h00, 1'b0);
        put(8'h66, xy, 1'b0);
        h = xy[4];
        if (!legacy || h) {m_t, m_f, m_v} = xy[7:5];
        m_ext = legacy ? 4'h0 : xy[3:0];
        if (!h) m_tag = legacy ? !m_t : xy[5];
        pulses_exp++;
        @(negedge clk);
        chk(sav_o == !h, "R1", "sav pulse", sav_o, !h);
        chk(eav_o == h,  "R1", "eav pulse", eav_o, h);
        if (legacy) chk({task_o, field_o, vblank_o} == {m_t, m_f, m_v}, "R4",
                        "flags", {task_o, field_o, vblank_o}, {m_t, m_f, m_v});
        else        chk({task_o, field_o, vblank_o} == {m_t, m_f, m_v}, "R5",
                        "flags", {task_o, field_o, vblank_o}, {m_t, m_f, m_v});
        chk(ext_o == m_ext, "R6", "ext flags", ext_o, m_ext);
        sample = {nup, nlo};
        if (nvalid) exp_q.push_back({m_tag, nup, nlo});
    endtask

    // Monitor: pops expected samples as valid data emerges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sav_o || eav_o) pulses_seen++;
            if (data_valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected valid sample", data_o, 0);
                end else begin
                    logic [DW:0] e;
                    e = exp_q.pop_front();
                    chk(data_o == e[DW-1:0], "R7", "sample data", data_o, e[DW-1:0]);
                    chk(tag_vbi_o == e[DW], "R8", "stream tag", tag_vbi_o, e[DW]);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        chk(1'b0, "watchdog", "run did not finish", 0, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({sav_o, eav_o, task_o, field_o, vblank_o, ext_o, data_valid_o, tag_vbi_o} == 0,
            "R9", "outputs in reset",
            {sav_o, eav_o, task_o, field_o, vblank_o, ext_o, data_valid_o, tag_vbi_o}, 0);
        chk(data_o == 0, "R9", "data in reset", data_o, 0);
        rst_n = 1'b1;
        repeat (3) put(8'h00, 8'h10, 1'b0);

        // Newer rules: active line with extended flags, upper-lane decoys (R3)
        code(8'hB1, 8'h00, 8'h10, 1'b0);
        code(8'h8A, 8'h22, 8'h41, 1'b1);
        put(8'h23, 8'h42, 1'b1);
        put(8'hFF, 8'h43, 1'b1);
        put(8'h00, 8'h44, 1'b1);
        put(8'h00, 8'h45, 1'b1);
        put(8'h80, 8'h46, 1'b1);
        put(8'h30, 8'hFF, 1'b1);    // R2: broken run inside a line
        put(8'h31, 8'h00, 1'b1);
        put(8'h32, 8'h47, 1'b1);
        code(8'h95, 8'h00, 8'h10, 1'b0);
        put(8'h00, 8'hFF, 1'b0);    // R2: broken run in blanking
        put(8'h00, 8'h00, 1'b0);
        put(8'h00, 8'h10, 1'b0);
        chk({task_o, field_o, vblank_o, ext_o} == {m_t, m_f, m_v, m_ext}, "R2",
            "flags after broken run", {task_o, field_o, vblank_o, ext_o},
            {m_t, m_f, m_v, m_ext});
        // Blanking-interval line, then a line of the other task
        code(8'h6C, 8'h01, 8'h50, 1'b1);
        put(8'h02, 8'h51, 1'b1);
        put(8'h03, 8'h52, 1'b1);
        code(8'h73, 8'h00, 8'h10, 1'b0);
        code(8'hC0, 8'h04, 8'h60, 1'b1);
        put(8'h05, 8'h61, 1'b1);
        code(8'hD0, 8'h00, 8'h10, 1'b0);

        // Legacy rules
        @(negedge clk);
        legacy = 1'b1;
        m_ext = 4'h0;
        put(8'h00, 8'h10, 1'b0);
        put(8'h00, 8'h10, 1'b0);
        chk(ext_o == 4'h0, "R6", "ext cleared in legacy", ext_o, 0);
        code(8'h7F, 8'h00, 8'h10, 1'b0);
        code(8'h86, 8'h10, 8'h70, 1'b1);
        put(8'h11, 8'h71, 1'b1);
        code(8'h90, 8'h00, 8'h10, 1'b0);
        code(8'h60, 8'h12, 8'h72, 1'b1);
        put(8'h13, 8'h73, 1'b1);
        code(8'h90, 8'h00, 8'h10, 1'b0);
        repeat (8) put(8'h00, 8'h10, 1'b0);

        chk(exp_q.size() == 0, "R7", "samples left undelivered", exp_q.size(), 0);
        chk(pulses_seen == pulses_exp, "R3", "code pulse count (R2 decoys too)",
            pulses_seen, pulses_exp);
        summary();
    end
endmodule